// File: doc/BRIEF.md
# Pulse-Pause Frame Transmitter

This block sends a reader-to-card command frame of up to 32 bits on a single carrier-enable line. Each bit begins with a short interval in which the carrier is switched off. The carrier is then switched back on. The value of the bit is carried by the total length of its period, measured from the start of that off interval. A logic 1 uses a long period and a logic 0 uses a short one. After the last bit, one more off interval marks the end of the frame, and the carrier then stays on.

Before a bit is encoded, it is XORed with one bit from an external keystream source. The block pulses an advance strobe once per bit, at the moment the carrier returns. Bits are sent least-significant first.

All timing is counted in ticks. One tick is `PRESCALE` clock cycles. A tick counter is cleared when a frame starts and again when it ends. Between frames its value is brought out, so that the surrounding logic can time the gap before the card replies.

Top module: `ppe_frame_tx`

## Requirements
- R1: Every carrier-off interval (`carrier` = 0), both for each bit and for the end-of-frame marker, lasts exactly PAUSE_TICKS*PRESCALE clock cycles.
- R2: The time from one falling edge of `carrier` to the next is ONE_TICKS*PRESCALE cycles for an encoded 1 and ZERO_TICKS*PRESCALE cycles for an encoded 0.
- R3: Encoded bit i is `frame_data[i] XOR` the keystream bit presented for bit i, and bit 0 (the LSB) is sent first.
- R4: `ks_adv` is high for exactly one cycle per sent bit, in the cycle in which `carrier` returns high after that bit's pause. It is not pulsed for the end-of-frame pause. `ks_bit` for the next bit is sampled after that pulse.
- R5: After the last bit, one terminating pause is sent and `carrier` then stays high. `done` is high for exactly one cycle, the same cycle in which `carrier` returns high after the terminating pause.
- R6: `start` is sampled at a rising clock edge while idle. `carrier` falls in the cycle right after that edge.
- R7: `busy` is high from the cycle after an accepted `start` up to the cycle before `done`. A `start` seen while `busy` is high is ignored and does not change the frame being sent.
- R8: A `frame_len` of 0 sends only the terminating pause. A `frame_len` above MAX_BITS is treated as MAX_BITS. Otherwise exactly `frame_len` bits are sent.
- R9: `elapsed` is 0 in the `done` cycle and then increases by one every PRESCALE cycles while idle.
- R10: While reset is asserted, `carrier` is 1, and `busy`, `done`, `ks_adv` and `elapsed` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Request to send a frame (taken only while idle) |
| frame_data | input | MAX_BITS | Payload, LSB sent first |
| frame_len | input | LEN_W | Number of bits to send, clamped to MAX_BITS |
| ks_bit | input | 1 | Current keystream bit |
| ks_adv | output | 1 | One-cycle request to step the keystream |
| carrier | output | 1 | Carrier enable (1 = on) |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| elapsed | output | CNT_W | Ticks since the last frame start or frame end |

## Verification
The carrier falls one cycle after the edge that samples `start`. After that, every edge of the line sits a whole number of ticks from that first fall. `ks_adv` and the return of the carrier share one cycle, and so do `done` and the carrier's final return. `elapsed` reaches k exactly k*PRESCALE cycles after `done`.

The bench timestamps every carrier edge and strobe in cycle counts taken at the falling clock edge. It drives inputs just after the rising edge. Each measured interval is therefore compared with an exact cycle count and no tolerance is used.

// File: rtl/ppe_pkg.sv
package ppe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GAP   = 2'd1,
    ST_MARK  = 2'd2,
    ST_TAIL  = 2'd3
  } ppe_state_e;
endpackage

// File: rtl/ppe_rst_sync.sv
module ppe_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/ppe_tick_gen.sv
module ppe_tick_gen #(
  parameter int PRESCALE = 32,
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  logic [PW-1:0] div_q, div_d;

  assign tick = (div_q == PW'(PRESCALE - 1));

  always_comb begin
    if (restart)   div_d = '0;
    else if (tick) div_d = '0;
    else           div_d = div_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/ppe_tick_counter.sv
module ppe_tick_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_d;
  logic             at_max;

  assign at_max = &count;

  always_comb begin
    cnt_d = count;
    if (clear)                cnt_d = '0;
    else if (tick && !at_max) cnt_d = count + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= cnt_d;
  end
endmodule

// File: rtl/ppe_frame_ctrl.sv
module ppe_frame_ctrl
  import ppe_pkg::*;
#(
  parameter int PAUSE_TICKS = 30,
  parameter int ONE_TICKS   = 150,
  parameter int ZERO_TICKS  = 90,
  parameter int MAX_BITS    = 32,
  parameter int CNT_W       = 16,
  localparam int LEN_W      = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [MAX_BITS-1:0] frame_data,
  input  logic [LEN_W-1:0]    frame_len,
  input  logic                ks_bit,
  input  logic                tick,
  input  logic [CNT_W-1:0]    tick_cnt,
  output logic                restart,
  output logic                clear,
  output logic                carrier,
  output logic                ks_adv,
  output logic                busy,
  output logic                done
);
  ppe_state_e          st_q, st_d;
  logic [MAX_BITS-1:0] sh_q, sh_d;
  logic [LEN_W-1:0]    rem_q, rem_d;
  logic                line_q, line_d;
  logic                adv_q, adv_d;
  logic                done_q, done_d;

  logic [LEN_W-1:0]    len_eff;
  logic [MAX_BITS-1:0] sh_next;
  logic                gap_over;
  logic                bit_over;

  assign len_eff  = (frame_len > LEN_W'(MAX_BITS)) ? LEN_W'(MAX_BITS) : frame_len;
  assign sh_next  = sh_q >> 1;
  assign gap_over = tick && (tick_cnt == CNT_W'(PAUSE_TICKS - 1));
  assign bit_over = tick && (tick_cnt == (line_q ? CNT_W'(ONE_TICKS - 1)
                                                 : CNT_W'(ZERO_TICKS - 1)));

  always_comb begin
    st_d    = st_q;
    sh_d    = sh_q;
    rem_d   = rem_q;
    line_d  = line_q;
    adv_d   = 1'b0;
    done_d  = 1'b0;
    restart = 1'b0;
    clear   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          restart = 1'b1;
          clear   = 1'b1;
          sh_d    = frame_data;
          rem_d   = len_eff;
          line_d  = frame_data[0] ^ ks_bit;
          st_d    = (len_eff == '0) ? ST_TAIL : ST_GAP;
        end
      end
      ST_GAP: begin
        if (gap_over) begin
          st_d  = ST_MARK;
          adv_d = 1'b1;
        end
      end
      ST_MARK: begin
        if (bit_over) begin
          clear = 1'b1;
          sh_d  = sh_next;
          rem_d = rem_q - LEN_W'(1);
          if (rem_q == LEN_W'(1)) begin
            st_d = ST_TAIL;
          end else begin
            st_d   = ST_GAP;
            line_d = sh_next[0] ^ ks_bit;
          end
        end
      end
      ST_TAIL: begin
        if (gap_over) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          clear  = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      rem_q  <= '0;
      line_q <= 1'b0;
      adv_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      rem_q  <= rem_d;
      line_q <= line_d;
      adv_q  <= adv_d;
      done_q <= done_d;
    end
  end

  assign carrier = !((st_q == ST_GAP) || (st_q == ST_TAIL));
  assign busy    = (st_q != ST_IDLE);
  assign ks_adv  = adv_q;
  assign done    = done_q;
endmodule

// File: rtl/ppe_frame_tx.sv
module ppe_frame_tx #(
  parameter int PRESCALE    = 32,
  parameter int PAUSE_TICKS = 30,
  parameter int ONE_TICKS   = 150,
  parameter int ZERO_TICKS  = 90,
  parameter int MAX_BITS    = 32,
  parameter int CNT_W       = 16,
  localparam int LEN_W      = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [MAX_BITS-1:0] frame_data,
  input  logic [LEN_W-1:0]    frame_len,
  input  logic                ks_bit,
  output logic                ks_adv,
  output logic                carrier,
  output logic                busy,
  output logic                done,
  output logic [CNT_W-1:0]    elapsed
);
  logic rst_q_n;
  logic tick;
  logic restart;
  logic clear;

  ppe_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  ppe_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .restart (restart),
    .tick    (tick)
  );

  ppe_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_q_n),
    .clear (clear),
    .tick  (tick),
    .count (elapsed)
  );

  ppe_frame_ctrl #(
    .PAUSE_TICKS (PAUSE_TICKS),
    .ONE_TICKS   (ONE_TICKS),
    .ZERO_TICKS  (ZERO_TICKS),
    .MAX_BITS    (MAX_BITS),
    .CNT_W       (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .start      (start),
    .frame_data (frame_data),
    .frame_len  (frame_len),
    .ks_bit     (ks_bit),
    .tick       (tick),
    .tick_cnt   (elapsed),
    .restart    (restart),
    .clear      (clear),
    .carrier    (carrier),
    .ks_adv     (ks_adv),
    .busy       (busy),
    .done       (done)
  );
endmodule

// File: rtl/ppe_frame_tx_chk.sv
module ppe_frame_tx_chk #(
  parameter int PRESCALE    = 32,
  parameter int PAUSE_TICKS = 30
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic carrier,
  input logic ks_adv,
  input logic busy,
  input logic done
);
  logic [31:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       low_cnt <= '0;
    else if (carrier) low_cnt <= '0;
    else              low_cnt <= low_cnt + 32'd1;
  end

  // R1
  pause_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carrier) |-> (low_cnt == 32'(PAUSE_TICKS * PRESCALE)));

  // R4
  adv_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ks_adv |-> $rose(carrier));

  // R4
  adv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ks_adv |=> !ks_adv);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (carrier && !busy));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R6
  start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !carrier));
endmodule

bind ppe_frame_tx ppe_frame_tx_chk #(
  .PRESCALE    (PRESCALE),
  .PAUSE_TICKS (PAUSE_TICKS)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_q_n),
  .start   (start),
  .carrier (carrier),
  .ks_adv  (ks_adv),
  .busy    (busy),
  .done    (done)
);

// File: tb/tb_ppe_frame_tx.sv
`timescale 1ns/1ps
module tb_ppe_frame_tx;
  localparam int P     = 2;
  localparam int PAUSE = 3;
  localparam int ONE   = 15;
  localparam int ZERO  = 9;
  localparam int NB    = 32;
  localparam int LW    = 6;
  localparam int CW    = 16;
  localparam int NV    = 6;

  // {data[31:0], len[5:0], ks[31:0]}
  localparam logic [69:0] VECS [0:NV-1] = '{
    {32'h0000_0055, 6'd7,  32'h0000_0000},
    {32'h0000_0019, 6'd6,  32'h0000_002A},
    {32'h0000_0ABC, 6'd12, 32'h0000_0F0F},
    {32'hFFFF_FFFF, 6'd32, 32'h1234_5678},
    {32'h0000_0001, 6'd1,  32'h0000_0001},
    {32'h0000_0003, 6'd2,  32'h0000_0000}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [NB-1:0] frame_data;
  logic [LW-1:0] frame_len;
  logic          ks_bit;
  logic          ks_adv;
  logic          carrier;
  logic          busy;
  logic          done;
  logic [CW-1:0] elapsed;

  int checks = 0;
  int fails  = 0;

  logic [31:0] cur_ks;
  int          clr_tok = 0;

  // monitor state (written only by the monitor)
  int          cyc = 0;
  int          clr_seen = 0;
  logic        prev_car = 1'b1;
  int          last_fall, start_cyc, first_fall, nfall, bad_period, bad_low;
  int          adv_cnt, adv_total = 0, ks_base = 0, done_cnt, done_cyc, last_rise;
  int          done_el, el5;
  logic [31:0] mon_bits;
  logic [4:0]  ks_idx;

  assign ks_idx = 5'(adv_total - ks_base);
  assign ks_bit = cur_ks[ks_idx];

  always #2 clk = ~clk;

  ppe_frame_tx #(
    .PRESCALE(P), .PAUSE_TICKS(PAUSE), .ONE_TICKS(ONE), .ZERO_TICKS(ZERO),
    .MAX_BITS(NB), .CNT_W(CW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_data(frame_data),
    .frame_len(frame_len), .ks_bit(ks_bit), .ks_adv(ks_adv),
    .carrier(carrier), .busy(busy), .done(done), .elapsed(elapsed)
  );

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (clr_tok != clr_seen) begin
      clr_seen   = clr_tok;
      start_cyc  = cyc;
      nfall      = 0;
      first_fall = -1;
      bad_period = 0;
      bad_low    = 0;
      adv_cnt    = 0;
      done_cnt   = 0;
      done_cyc   = -100000;
      last_rise  = -1;
      mon_bits   = '0;
      done_el    = -1;
      el5        = -1;
      ks_base    = adv_total;
    end
    if (prev_car && !carrier) begin
      if (nfall == 0) first_fall = cyc;
      else if (nfall <= 32) begin
        if (cyc - last_fall == ONE * P)       mon_bits[nfall-1] = 1'b1;
        else if (cyc - last_fall == ZERO * P) mon_bits[nfall-1] = 1'b0;
        else bad_period = bad_period + 1;
      end
      nfall     = nfall + 1;
      last_fall = cyc;
    end
    if (!prev_car && carrier) begin
      if (cyc - last_fall != PAUSE * P) bad_low = bad_low + 1;
      last_rise = cyc;
    end
    if (ks_adv) begin
      adv_cnt   = adv_cnt + 1;
      adv_total = adv_total + 1;
    end
    if (done) begin
      done_cnt = done_cnt + 1;
      done_cyc = cyc;
      done_el  = int'(elapsed);
    end
    if (cyc == done_cyc + 5 * P) el5 = int'(elapsed);
    prev_car = carrier;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input logic [31:0] data, input logic [5:0] len,
                           input logic [31:0] ks, input bit inject);
    int          n;
    logic [31:0] exp_bits;
    bit          seen;
    n = (len > 6'd32) ? 32 : int'(len);
    exp_bits = (n == 32) ? (data ^ ks) : ((data ^ ks) & ((32'd1 << n) - 32'd1));
    @(posedge clk); #1;
    frame_data = data; frame_len = len; cur_ks = ks; start = 1'b1;
    clr_tok = clr_tok + 1;
    @(posedge clk); #1;
    start = 1'b0;
    if (inject) begin
      repeat (20) @(posedge clk);
      #1;
      chk(busy == 1'b1, "R7", "busy mid-frame", busy, 1);
      frame_data = ~data; frame_len = 6'd5; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
    end
    seen = 1'b0;
    for (int i = 0; i < 4000 && !seen; i++) begin
      @(posedge clk);
      if (done_cnt > 0) seen = 1'b1;
    end
    chk(seen, "R5", "done seen", seen, 1);
    repeat (5 * P + 4) @(posedge clk);
    #1;
    chk(nfall == n + 1, "R8", "carrier falls", nfall, n + 1);
    chk(mon_bits == exp_bits, "R3", "decoded bits", mon_bits, exp_bits);
    chk(bad_period == 0, "R2", "bad bit periods", bad_period, 0);
    chk(bad_low == 0, "R1", "bad pause lengths", bad_low, 0);
    chk(adv_cnt == n, "R4", "ks_adv pulses", adv_cnt, n);
    chk(done_cnt == 1, "R5", "done pulses", done_cnt, 1);
    chk(done_cyc == last_rise, "R5", "done vs final rise", done_cyc, last_rise);
    chk(carrier == 1'b1, "R5", "carrier after frame", carrier, 1);
    chk(first_fall - start_cyc == 1, "R6", "start to first fall", first_fall - start_cyc, 1);
    chk(busy == 1'b0, "R7", "busy after done", busy, 0);
    chk(done_el == 0, "R9", "elapsed at done", done_el, 0);
    chk(el5 == 5, "R9", "elapsed 5 ticks after done", el5, 5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; frame_data = '0; frame_len = '0; cur_ks = '0;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk(carrier == 1'b1, "R10", "carrier in reset", carrier, 1);
    chk(busy == 1'b0,    "R10", "busy in reset", busy, 0);
    chk(done == 1'b0,    "R10", "done in reset", done, 0);
    chk(ks_adv == 1'b0,  "R10", "ks_adv in reset", ks_adv, 0);
    chk(elapsed == '0,   "R10", "elapsed in reset", elapsed, 0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);

    for (int v = 0; v < NV; v++) begin
      run_frame(VECS[v][69:38], VECS[v][37:32], VECS[v][31:0], 1'b0);
    end

    // R8 zero-length frame: only the terminating pause
    run_frame(32'hDEAD_BEEF, 6'd0, 32'h0, 1'b0);
    // R8 over-long count clamps to 32
    run_frame(32'hA5A5_A5A5, 6'd45, 32'h0F0F_0F0F, 1'b0);
    // R7 start while busy is ignored
    run_frame(32'h0000_00B6, 6'd8, 32'h0000_0033, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule